// File: doc/BRIEF.md
# Low-Power Link-Up Speed Sequencer

This block chooses which copper link speeds the PHY offers during auto-negotiation while the device sits in a reduced power state. In that state the block starts with the slowest speed only. If that attempt fails, it widens the offer to every speed and turns on parallel detect. Crossover (MDI/MDI-X) resolution runs only in the narrow first step. The block keeps retrying until the link comes up or until a stop input holds it back.

When the device is fully active, or when low-power link-up is turned off, the user speed advertisement passes straight through. In a non-active state with no consumer needing the link (manageability, wake-up or power-management event), the PHY enable is dropped and nothing is offered. The low-power enable is loaded from a configuration pin during reset. Software may overwrite it at any time, and a write takes effect on the same clock edge. A registered energy-detect flag mirrors line energy.

Top module: `lnk_speed_seq`

## Requirements
- R1: While reset (`rstN`, synchronous, active low) is held, every output reads 0, and `lowPwrEn` loads from `cfgLowPwrInit`.
- R2: On entry into low-power negotiation, the block advertises mask 3'b001 with crossover enabled and parallel detect off, and pulses `restartNeg` for one cycle. Entry means a non-active power state with the enable set and at least one need, following a cycle that did not meet this or that had a different power code. The mask is bit0 = 10 Mb/s, bit1 = 100 Mb/s, bit2 = 1000 Mb/s. The user advertisement is ignored here.
- R3: A fail strobe in the narrow step changes the mask to 3'b111, sets parallel detect, clears crossover and pulses `restartNeg`.
- R4: A fail strobe in the wide step pulses `restartNeg` again and keeps mask 3'b111.
- R5: While `stopRetry` is high, a fail strobe causes no restart pulse and no change of mask.
- R6: A done strobe holds the current mask with no restart. Fail strobes are then ignored.
- R7: A `linkLost` strobe after link-up returns the block to mask 3'b001 with a restart pulse.
- R8: A change between non-active power codes (2'b01 uninitialised active, 2'b10 sleep, 2'b11 power-up reset) restarts at 3'b001, even when the link is up.
- R9: In power code 2'b00 (fully active), or with the enable clear, the mask equals `userAdv`. Parallel detect and crossover are both on, and fail strobes have no effect.
- R10: In a non-active code with `needMng`, `needWake` and `needPme` all low, `phyEnable` is 0 and the mask is 3'b000. Any one need keeps the PHY enabled.
- R11: A software write (`swWr`/`swData`) takes effect on its own edge. Clearing the enable moves the block to pass-through. Setting it while in a needed non-active state is an entry (R2).
- R12: `energyDet` equals `energyIn` delayed by one cycle and reads 0 from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgLowPwrInit | input | 1 | Reset-time value of the low-power enable |
| swWr | input | 1 | Software write strobe for the enable |
| swData | input | 1 | Value written by software |
| pwrState | input | 2 | Power state code |
| needMng | input | 1 | Link needed by manageability |
| needWake | input | 1 | Link needed by wake-up logic |
| needPme | input | 1 | Link needed by power-management events |
| stopRetry | input | 1 | Suppress retries after failure |
| negDone | input | 1 | Negotiation success strobe |
| negFail | input | 1 | Negotiation failure strobe |
| linkLost | input | 1 | Link loss strobe |
| userAdv | input | 3 | User speed advertisement |
| energyIn | input | 1 | Raw line energy indication |
| advMask | output | 3 | Advertised speed mask |
| restartNeg | output | 1 | Restart-negotiation pulse |
| parDetEn | output | 1 | Parallel detect enable |
| mdixEn | output | 1 | Crossover resolution enable |
| phyEnable | output | 1 | PHY enable |
| energyDet | output | 1 | Energy detect status |

## Verification
A wrong sequencer state shows up at the ports one edge after the stimulus that exposes it. A missed entry leaves the mask at the user value or a stale 3'b111 where 3'b001 is due. A missed widening keeps 3'b001 with no restart after a failure. A spurious or lost restart pulse appears, or fails to appear, in that same cycle. The scoreboard therefore checks every output on every cycle, so any divergence is caught within one clock of its cause.

// File: rtl/lnk_seq_pkg.sv
package lnk_seq_pkg;
  localparam int SPD_W = 3;
  localparam int PWR_W = 2;
  localparam logic [SPD_W-1:0] MASK_SLOW = SPD_W'(1);
  localparam logic [SPD_W-1:0] MASK_ALL  = {SPD_W{1'b1}};
  localparam logic [PWR_W-1:0] PWR_ACTIVE = '0;

  typedef enum logic [2:0] {
    ST_OFF, ST_PASS, ST_NARROW, ST_WIDE, ST_LINKED
  } seqState_t;

  typedef struct packed {
    logic goOff;
    logic goPass;
    logic goNarrow;
    logic goWide;
    logic restart;
  } seqStrb_t;
endpackage

// File: rtl/lnk_seq_ctrl.sv
module lnk_seq_ctrl
  import lnk_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLowPwrInit,
  input  logic             swWr,
  input  logic             swData,
  input  logic [PWR_W-1:0] pwrState,
  input  logic             needAny,
  input  logic             stopRetry,
  input  logic             negDone,
  input  logic             negFail,
  input  logic             linkLost,
  output seqStrb_t         strb
);
  seqState_t        stateQ, stateD;
  logic             lowPwrEn, lowPwrEff;
  logic             lpModeQ, lpMode, nonAct;
  logic [PWR_W-1:0] pwrQ;

  assign nonAct    = (pwrState != PWR_ACTIVE);
  assign lowPwrEff = swWr ? swData : lowPwrEn;
  assign lpMode    = nonAct && lowPwrEff && needAny;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    if (nonAct && !needAny) begin
      stateD = ST_OFF;
      strb.goOff = 1'b1;
    end else if (!(nonAct && lowPwrEff)) begin
      stateD = ST_PASS;
      strb.goPass = 1'b1;
    end else if (!lpModeQ || pwrState != pwrQ) begin
      stateD = ST_NARROW;
      strb.goNarrow = 1'b1;
      strb.restart = 1'b1;
    end else begin
      unique case (stateQ)
        ST_NARROW: begin
          if (negDone) stateD = ST_LINKED;
          else if (negFail && !stopRetry) begin
            stateD = ST_WIDE;
            strb.goWide = 1'b1;
            strb.restart = 1'b1;
          end
        end
        ST_WIDE: begin
          if (negDone) stateD = ST_LINKED;
          else if (negFail && !stopRetry) strb.restart = 1'b1;
        end
        ST_LINKED: begin
          if (linkLost) begin
            stateD = ST_NARROW;
            strb.goNarrow = 1'b1;
            strb.restart = 1'b1;
          end
        end
        default: begin
          stateD = ST_NARROW;
          strb.goNarrow = 1'b1;
          strb.restart = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_OFF;
      lpModeQ  <= 1'b0;
      pwrQ     <= PWR_ACTIVE;
      lowPwrEn <= cfgLowPwrInit;
    end else begin
      stateQ   <= stateD;
      lpModeQ  <= lpMode;
      pwrQ     <= pwrState;
      lowPwrEn <= lowPwrEff;
    end
  end

  // stop input suppresses every retry once in a settled low-power mode
  assert_no_retry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stopRetry && !linkLost && lpMode && lpModeQ && pwrState == pwrQ) |-> !strb.restart);

  // once linked, nothing but link loss or a mode change leaves that state
  assert_hold_link_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LINKED && lpMode && lpModeQ && pwrState == pwrQ && !linkLost)
      |=> stateQ == ST_LINKED);
endmodule

// File: rtl/lnk_seq_dp.sv
module lnk_seq_dp
  import lnk_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrb_t         strb,
  input  logic [SPD_W-1:0] userAdv,
  input  logic             energyIn,
  output logic [SPD_W-1:0] advMask,
  output logic             restartNeg,
  output logic             parDetEn,
  output logic             mdixEn,
  output logic             phyEnable,
  output logic             energyDet
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      advMask    <= '0;
      restartNeg <= 1'b0;
      parDetEn   <= 1'b0;
      mdixEn     <= 1'b0;
      phyEnable  <= 1'b0;
      energyDet  <= 1'b0;
    end else begin
      restartNeg <= strb.restart;
      energyDet  <= energyIn;
      if (strb.goOff) begin
        advMask <= '0; parDetEn <= 1'b0; mdixEn <= 1'b0; phyEnable <= 1'b0;
      end else if (strb.goPass) begin
        advMask <= userAdv; parDetEn <= 1'b1; mdixEn <= 1'b1; phyEnable <= 1'b1;
      end else if (strb.goNarrow) begin
        advMask <= MASK_SLOW; parDetEn <= 1'b0; mdixEn <= 1'b1; phyEnable <= 1'b1;
      end else if (strb.goWide) begin
        advMask <= MASK_ALL; parDetEn <= 1'b1; mdixEn <= 1'b0; phyEnable <= 1'b1;
      end
    end
  end

  // widening step always opens parallel detect and closes crossover resolve
  assert_widen_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.goWide |=> (parDetEn && !mdixEn && advMask == MASK_ALL));
endmodule

// File: rtl/lnk_speed_seq.sv
module lnk_speed_seq
  import lnk_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLowPwrInit,
  input  logic             swWr,
  input  logic             swData,
  input  logic [PWR_W-1:0] pwrState,
  input  logic             needMng,
  input  logic             needWake,
  input  logic             needPme,
  input  logic             stopRetry,
  input  logic             negDone,
  input  logic             negFail,
  input  logic             linkLost,
  input  logic [SPD_W-1:0] userAdv,
  input  logic             energyIn,
  output logic [SPD_W-1:0] advMask,
  output logic             restartNeg,
  output logic             parDetEn,
  output logic             mdixEn,
  output logic             phyEnable,
  output logic             energyDet
);
  seqStrb_t strb;
  logic     needAny;

  assign needAny = needMng | needWake | needPme;

  lnk_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLowPwrInit(cfgLowPwrInit), .swWr(swWr),
    .swData(swData), .pwrState(pwrState), .needAny(needAny),
    .stopRetry(stopRetry), .negDone(negDone), .negFail(negFail),
    .linkLost(linkLost), .strb(strb)
  );

  lnk_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .userAdv(userAdv), .energyIn(energyIn),
    .advMask(advMask), .restartNeg(restartNeg), .parDetEn(parDetEn),
    .mdixEn(mdixEn), .phyEnable(phyEnable), .energyDet(energyDet)
  );

  // a restart only ever goes out with the slow-only or all-speeds offer
  assert_restart_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    restartNeg |-> (advMask == MASK_SLOW || advMask == MASK_ALL));

  // fully active state mirrors the user offer one edge later
  assert_pass_user_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PWR_ACTIVE) |=> advMask == $past(userAdv));

  // unneeded non-active state shuts the PHY
  assert_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != PWR_ACTIVE && !needAny) |=> (!phyEnable && advMask == '0));
endmodule

// File: tb/sim_lnk_speed_seq.sv
module sim_lnk_speed_seq;
  logic clk = 1'b0;
  logic rstN, cfgLowPwrInit, swWr, swData, needMng, needWake, needPme;
  logic stopRetry, negDone, negFail, linkLost, energyIn;
  logic [1:0] pwrState;
  logic [2:0] userAdv, advMask;
  logic restartNeg, parDetEn, mdixEn, phyEnable, energyDet;

  // staged stimulus, applied by the driver at a falling edge
  logic sRst = 1'b0, sCfg = 1'b1, sWr = 1'b0, sData = 1'b0;
  logic sMng = 1'b0, sWake = 1'b0, sPme = 1'b0, sStop = 1'b0;
  logic sDone = 1'b0, sFail = 1'b0, sLost = 1'b0, sEnergy = 1'b0;
  logic [1:0] sPwr = 2'b11;
  logic [2:0] sUser = 3'b000;

  typedef struct {
    logic [2:0] adv;
    logic rst, pd, mdix, phy, en;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  int checks = 0, errors = 0;
  bit doneFlag = 1'b0;

  always #4 clk = ~clk;

  lnk_speed_seq u0 (
    .clk(clk), .rstN(rstN), .cfgLowPwrInit(cfgLowPwrInit), .swWr(swWr),
    .swData(swData), .pwrState(pwrState), .needMng(needMng), .needWake(needWake),
    .needPme(needPme), .stopRetry(stopRetry), .negDone(negDone), .negFail(negFail),
    .linkLost(linkLost), .userAdv(userAdv), .energyIn(energyIn),
    .advMask(advMask), .restartNeg(restartNeg), .parDetEn(parDetEn),
    .mdixEn(mdixEn), .phyEnable(phyEnable), .energyDet(energyDet)
  );

  task automatic tick(input logic [2:0] adv, input logic rst, input logic pd,
                      input logic mdix, input logic phy, input logic en, input string tag);
    expItem_t it;
    @(negedge clk);
    rstN = sRst; cfgLowPwrInit = sCfg; swWr = sWr; swData = sData;
    pwrState = sPwr; needMng = sMng; needWake = sWake; needPme = sPme;
    stopRetry = sStop; negDone = sDone; negFail = sFail; linkLost = sLost;
    userAdv = sUser; energyIn = sEnergy;
    sWr = 1'b0; sDone = 1'b0; sFail = 1'b0; sLost = 1'b0;
    it.adv = adv; it.rst = rst; it.pd = pd; it.mdix = mdix; it.phy = phy; it.en = en;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        logic [7:0] act, want;
        e = expQ.pop_front();
        act  = {advMask, restartNeg, parDetEn, mdixEn, phyEnable, energyDet};
        want = {e.adv, e.rst, e.pd, e.mdix, e.phy, e.en};
        checks++;
        if (act !== want) begin
          errors++;
          $display("FAIL %s: actual adv/rst/pd/mdix/phy/en=%b expected %b", e.tag, act, want);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!doneFlag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    sRst = 1'b0; sCfg = 1'b1; sPwr = 2'b11; sMng = 1'b1; sUser = 3'b110;
    tick(3'b000, 0, 0, 0, 0, 0, "R1 reset");
    sRst = 1'b1;
    tick(3'b001, 1, 0, 1, 1, 0, "R2 power-up entry ignores user");
    tick(3'b001, 0, 0, 1, 1, 0, "R2 single pulse");
    sFail = 1'b1;
    tick(3'b111, 1, 1, 0, 1, 0, "R3 widen on fail");
    sFail = 1'b1;
    tick(3'b111, 1, 1, 0, 1, 0, "R4 retry wide");
    sStop = 1'b1; sFail = 1'b1;
    tick(3'b111, 0, 1, 0, 1, 0, "R5 stop suppresses retry");
    sStop = 1'b0; sDone = 1'b1;
    tick(3'b111, 0, 1, 0, 1, 0, "R6 link up holds");
    sFail = 1'b1;
    tick(3'b111, 0, 1, 0, 1, 0, "R6 fail ignored when linked");
    sLost = 1'b1;
    tick(3'b001, 1, 0, 1, 1, 0, "R7 link loss back to slow");
    sDone = 1'b1;
    tick(3'b001, 0, 0, 1, 1, 0, "R6 linked at slow");
    sPwr = 2'b10;
    tick(3'b001, 1, 0, 1, 1, 0, "R8 code change to sleep");
    sPwr = 2'b01;
    tick(3'b001, 1, 0, 1, 1, 0, "R8 code change to uninit");
    sPwr = 2'b00; sUser = 3'b110;
    tick(3'b110, 0, 1, 1, 1, 0, "R9 active passes user");
    sUser = 3'b011; sFail = 1'b1;
    tick(3'b011, 0, 1, 1, 1, 0, "R9 fail no effect");
    sPwr = 2'b10; sMng = 1'b0; sWake = 1'b1;
    tick(3'b001, 1, 0, 1, 1, 0, "R10 wake need enters");
    sWake = 1'b0;
    tick(3'b000, 0, 0, 0, 0, 0, "R10 no need disables");
    sPme = 1'b1;
    tick(3'b001, 1, 0, 1, 1, 0, "R10 pme need re-enters");
    sWr = 1'b1; sData = 1'b0;
    tick(3'b011, 0, 1, 1, 1, 0, "R11 clear enable passes user");
    tick(3'b011, 0, 1, 1, 1, 0, "R11 stays pass");
    sWr = 1'b1; sData = 1'b1;
    tick(3'b001, 1, 0, 1, 1, 0, "R11 set enable is entry");
    sEnergy = 1'b1;
    tick(3'b001, 0, 0, 1, 1, 1, "R12 energy seen");
    sEnergy = 1'b0;
    tick(3'b001, 0, 0, 1, 1, 0, "R12 energy gone");
    sRst = 1'b0; sCfg = 1'b0;
    tick(3'b000, 0, 0, 0, 0, 0, "R1 second reset");
    sRst = 1'b1;
    tick(3'b011, 0, 1, 1, 1, 0, "R11 cfg load clear gives pass");
    @(negedge clk);
    @(negedge clk);
    doneFlag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule